// File: doc/BRIEF.md
# Multi-Tap Audio Echo Generator

This block is a streaming audio effect. Each incoming signed PCM sample is stored in a circular sample buffer. The output sample is the live sample plus up to four earlier samples, one read from each enabled reflection tap at that tap's own delay. The sum is formed at a wider width and then clamped to the signed output range. After reset, tap count 1 gives a single echo that lags by 800 samples, which is 100 ms at an 8 kHz sample rate. Several taps with different delays give a set of distinct reflections.

Tap delays are set through a plain write strobe. Each write carries a tap index, a kind bit and a value. The value is either a delay in samples or a reflector distance in whole metres. A distance is turned into the round-trip travel time of sound at 343 m/s, expressed in samples, using one constant multiply and a rounding shift. The number of active taps is a runtime input.

Samples enter and leave on valid/ready streams. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held unchanged and intake stops.

Top module: `echo_multitap`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, every tap delay is 800 samples, and the buffer reads as all zeros.
- R2: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R3: Exactly one output is produced per accepted input, in order. With no back-pressure, the output for a sample accepted on edge k becomes valid on edge k+1, which is two clock cycles after the sample was presented.
- R4: With `tap_count` = 0, `out_data` equals the accepted input sample.
- R5: With the reset delays and `tap_count` = 1, the output for sample n is x[n] + x[n-800].
- R6: The output for sample n is x[n] plus the sum, over taps i below min(`tap_count`, 4), of x[n - d_i]. A `tap_count` of 5 to 7 acts as 4.
- R7: A tap whose delay reaches back before the first sample accepted since reset contributes zero.
- R8: The sum saturates to the range -32768 to 32767 and never wraps.
- R9: A write with `cfg_dist` = 0 sets the delay of tap `cfg_tap` to `cfg_value`, clamped to 1..1023. The new delay applies to samples accepted after the write edge.
- R10: A write with `cfg_dist` = 1 sets the delay of tap `cfg_tap` to round(`cfg_value` × 16000 / 343), clamped to 1..1023. For example, 7 m gives 327, 10 m gives 466, 0 m gives 1 and 50 m gives 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample is present |
| out_ready | input | 1 | Consumer takes the output sample |
| out_data | output | 16 | Signed mixed and saturated sample |
| tap_count | input | 3 | Number of active taps (values above 4 act as 4) |
| cfg_wr | input | 1 | Tap delay write strobe |
| cfg_tap | input | 2 | Tap index for the write |
| cfg_dist | input | 1 | 0: value is a delay in samples, 1: value is a distance in metres |
| cfg_value | input | 12 | Delay or distance value |

## Verification
On every cycle, the assertions check the handshake rules:
- the held output during a stall;
- ready whenever the output is empty;
- the one-edge pipeline advance after acceptance;
- that no tap delay ever leaves the range 1..1023.

The arithmetic can only be shown by the bench's scenarios, which compare each output with a reference model fed the full sample history. The arithmetic covered this way includes the dry pass-through, the default 800-sample echo, multi-tap sums with clamped tap counts, the zero history after reset, saturation at both rails, and the distance conversion.

// File: rtl/echo_pkg.sv
package echo_pkg;
  // propagation speed used for reflector distance conversion (m/s)
  localparam int SOUND_MPS = 343;

  // meaning of the value carried by a tap configuration write
  typedef enum logic {
    CFG_DELAY = 1'b0,
    CFG_DIST  = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/echo_tap_regs.sv
module echo_tap_regs
  import echo_pkg::*;
#(
  parameter int NTAPS       = 4,
  parameter int ADDR_W      = 10,
  parameter int CFG_W       = 12,
  parameter int SAMPLE_HZ   = 8000,
  parameter int RESET_DELAY = 800,
  parameter int FRAC_W      = 8,
  parameter int TAP_IDX_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic [TAP_IDX_W-1:0]          cfg_tap,
  input  logic                          cfg_dist,
  input  logic [CFG_W-1:0]              cfg_value,
  output logic [NTAPS-1:0][ADDR_W-1:0]  tap_delay
);
  localparam int     DEPTH  = 1 << ADDR_W;
  // round-trip samples per metre, scaled by 2^FRAC_W
  localparam longint SCALE  = ((longint'(2 * SAMPLE_HZ) << FRAC_W) + SOUND_MPS / 2) / SOUND_MPS;
  localparam int     K_W    = $clog2(SCALE + 1);
  localparam int     PROD_W = CFG_W + K_W;
  localparam longint HALF   = longint'(1) << (FRAC_W - 1);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] raw;
  logic [ADDR_W-1:0] clamped;

  always_comb begin
    prod = PROD_W'(cfg_value) * PROD_W'(SCALE);
    if (cfg_kind_e'(cfg_dist) == CFG_DIST)
      raw = (prod + PROD_W'(HALF)) >> FRAC_W;
    else
      raw = PROD_W'(cfg_value);
    if (raw == '0)
      clamped = ADDR_W'(1);
    else if (raw > PROD_W'(DEPTH - 1))
      clamped = ADDR_W'(DEPTH - 1);
    else
      clamped = raw[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) tap_delay[i] <= ADDR_W'(RESET_DELAY);
    end else if (cfg_wr) begin
      for (int i = 0; i < NTAPS; i++)
        if (cfg_tap == TAP_IDX_W'(i)) tap_delay[i] <= clamped;
    end
  end
endmodule

// File: rtl/echo_sample_ram.sv
module echo_sample_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int NRD    = 4
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         rd_en,
  input  logic [NRD-1:0][ADDR_W-1:0]   rd_addr,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read ports, all sampled on the accepting edge
  always_ff @(posedge clk) begin
    if (rd_en) begin
      for (int p = 0; p < NRD; p++) rd_data[p] <= mem[rd_addr[p]];
    end
  end
endmodule

// File: rtl/echo_mix_sat.sv
module echo_mix_sat #(
  parameter int DATA_W = 16,
  parameter int NTAPS  = 4
) (
  input  logic [DATA_W-1:0]             dry,
  input  logic [NTAPS-1:0][DATA_W-1:0]  taps,
  input  logic [NTAPS-1:0]              tap_en,
  output logic [DATA_W-1:0]             mixed
);
  localparam int     SUM_W = DATA_W + $clog2(NTAPS + 1);
  localparam longint HI    = (longint'(1) << (DATA_W - 1)) - 1;
  localparam longint LO    = -(longint'(1) << (DATA_W - 1));
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'(HI);
  localparam logic signed [SUM_W-1:0] SAT_LO = SUM_W'(LO);

  logic signed [SUM_W-1:0] acc;

  always_comb begin
    acc = SUM_W'($signed(dry));
    for (int i = 0; i < NTAPS; i++)
      if (tap_en[i]) acc = acc + SUM_W'($signed(taps[i]));
    if (acc > SAT_HI)
      mixed = SAT_HI[DATA_W-1:0];
    else if (acc < SAT_LO)
      mixed = SAT_LO[DATA_W-1:0];
    else
      mixed = acc[DATA_W-1:0];
  end
endmodule

// File: rtl/echo_multitap.sv
module echo_multitap
  import echo_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 10,
  parameter int NTAPS       = 4,
  parameter int TCNT_W      = 3,
  parameter int CFG_W       = 12,
  parameter int SAMPLE_HZ   = 8000,
  parameter int RESET_DELAY = 800,
  parameter int FRAC_W      = 8,
  parameter int TAP_IDX_W   = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_W-1:0]    out_data,
  input  logic [TCNT_W-1:0]    tap_count,
  input  logic                 cfg_wr,
  input  logic [TAP_IDX_W-1:0] cfg_tap,
  input  logic                 cfg_dist,
  input  logic [CFG_W-1:0]     cfg_value
);
  localparam int DEPTH = 1 << ADDR_W;

  logic                        accept;
  logic                        advance;
  logic [NTAPS-1:0][ADDR_W-1:0] tap_delay;
  logic [NTAPS-1:0][ADDR_W-1:0] rd_addr;
  logic [NTAPS-1:0][DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0]           wr_ptr;
  logic [ADDR_W-1:0]           fill;
  logic [TCNT_W-1:0]           eff_count;
  logic [NTAPS-1:0]            tap_en_d;
  logic [NTAPS-1:0]            tap_en_q;
  logic                        stg1_valid;
  logic [DATA_W-1:0]           dry_q;
  logic [DATA_W-1:0]           mixed;

  // whole pipeline moves when the output slot is free or being drained
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && in_ready;

  assign eff_count = (tap_count > TCNT_W'(NTAPS)) ? TCNT_W'(NTAPS) : tap_count;

  echo_tap_regs #(
    .NTAPS(NTAPS), .ADDR_W(ADDR_W), .CFG_W(CFG_W), .SAMPLE_HZ(SAMPLE_HZ),
    .RESET_DELAY(RESET_DELAY), .FRAC_W(FRAC_W), .TAP_IDX_W(TAP_IDX_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_tap(cfg_tap),
    .cfg_dist(cfg_dist), .cfg_value(cfg_value), .tap_delay(tap_delay)
  );

  // per-tap read address and history qualification
  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    assign rd_addr[g]  = wr_ptr - tap_delay[g];
    assign tap_en_d[g] = (TCNT_W'(g) < eff_count) && (tap_delay[g] <= fill);
  end

  echo_sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NRD(NTAPS)) ram_i (
    .clk(clk), .wr_en(accept), .wr_addr(wr_ptr), .wr_data(in_data),
    .rd_en(accept), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else if (accept) begin
      wr_ptr <= wr_ptr + ADDR_W'(1);
      if (fill != ADDR_W'(DEPTH - 1)) fill <= fill + ADDR_W'(1);
    end
  end

  // stage 1: dry sample and tap enables, aligned with the RAM read data
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg1_valid <= 1'b0;
      dry_q      <= '0;
      tap_en_q   <= '0;
    end else if (advance) begin
      stg1_valid <= accept;
      dry_q      <= in_data;
      tap_en_q   <= tap_en_d;
    end
  end

  echo_mix_sat #(.DATA_W(DATA_W), .NTAPS(NTAPS)) mix_i (
    .dry(dry_q), .taps(rd_data), .tap_en(tap_en_q), .mixed(mixed)
  );

  // stage 2: output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (advance) begin
      out_valid <= stg1_valid;
      if (stg1_valid) out_data <= mixed;
    end
  end
endmodule

// File: rtl/echo_multitap_chk.sv
module echo_multitap_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int NTAPS  = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic [DATA_W-1:0]            out_data,
  input logic [NTAPS-1:0][ADDR_W-1:0] tap_delay
);
  // R2: stalled output stays put
  p_hold_when_stalled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2: empty output slot means intake is open
  p_ready_when_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R3: accepted sample reaches the output one edge later when not stalled
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 (!out_valid || out_ready) |=> out_valid);

  // R9, R10: every tap delay stays inside 1..DEPTH-1
  for (genvar g = 0; g < NTAPS; g++) begin : g_rng
    p_delay_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tap_delay[g] != '0);
  end
endmodule

bind echo_multitap echo_multitap_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NTAPS(NTAPS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .tap_delay(tap_delay)
);

// File: tb/echo_multitap_tb_top.sv
module echo_multitap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic [2:0]  tap_count = '0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_tap = '0;
  logic        cfg_dist = 1'b0;
  logic [11:0] cfg_value = '0;

  int    checks = 0;
  int    errors = 0;
  int    hist [0:16383];
  int    n_acc = 0;
  int    mdl_delay [4];
  int    exp_q [$];
  string tag_q [$];
  string cur_tag = "R1";
  bit    prev_stall = 1'b0;
  logic [15:0] held = '0;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  echo_multitap dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .tap_count(tap_count), .cfg_wr(cfg_wr),
    .cfg_tap(cfg_tap), .cfg_dist(cfg_dist), .cfg_value(cfg_value)
  );

  function automatic int clamp_d(int v);
    if (v < 1) return 1;
    if (v > 1023) return 1023;
    return v;
  endfunction

  function automatic int dist_ref(int m);
    return clamp_d($rtoi(m * 16000.0 / 343.0 + 0.5));
  endfunction

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int model(int x, int tc);
    int eff = (tc > 4) ? 4 : tc;
    int s = x;
    for (int i = 0; i < eff; i++)
      if (mdl_delay[i] <= n_acc) s += hist[n_acc - mdl_delay[i]];
    return sat16(s);
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic observe(int tc);
    if (prev_stall) begin
      check("R2 valid held", int'(out_valid), 1);
      check("R2 data held", int'(out_data), int'(held));
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected output", 1, 0);
      end else begin
        check(tag_q.pop_front(), int'($signed(out_data)), exp_q.pop_front());
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(model(int'($signed(in_data)), tc));
      tag_q.push_back(cur_tag);
      hist[n_acc] = int'($signed(in_data));
      n_acc++;
    end
    prev_stall = out_valid && !out_ready;
    held = out_data;
  endtask

  task automatic step(bit iv, int data, bit ordy, int tc);
    @(negedge clk);
    cfg_wr = 1'b0;
    in_valid = iv;
    in_data = 16'(data);
    out_ready = ordy;
    tap_count = 3'(tc);
    #1;
    observe(tc);
  endtask

  task automatic cfg(int t, bit d, int v);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    cfg_wr = 1'b1;
    cfg_tap = 2'(t);
    cfg_dist = d;
    cfg_value = 12'(v);
    #1;
    observe(int'(tap_count));
    mdl_delay[t] = d ? dist_ref(v) : clamp_d(v);
  endtask

  task automatic drain(int tc);
    for (int i = 0; i < 60; i++) step(1'b0, 0, 1'b1, tc);
    check("R3 all outputs delivered", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mdl_delay[i] = 800;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    cur_tag = "R1";
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);

    // R3 latency and R4 dry pass-through
    cur_tag = "R4";
    step(1'b1, 1234, 1'b1, 0);
    step(1'b0, 0, 1'b1, 0);
    check("R3 not valid after one edge", int'(out_valid), 0);
    step(1'b0, 0, 1'b1, 0);
    check("R3 valid after two edges", int'(out_valid), 1);
    for (int i = 0; i < 20; i++) step(1'b1, int'($urandom) % 20000 - 10000, 1'b1, 0);
    drain(0);

    // R7 empty history, then R5 default single echo at 800 samples
    for (int i = 0; i < 1000; i++) begin
      cur_tag = (n_acc < 800) ? "R7" : "R5";
      step(1'b1, int'($urandom % 16000) - 8000, 1'b1, 1);
    end
    drain(1);

    // R9 delay writes with clamping, R6 multi-tap with clamped count
    cfg(0, 1'b0, 0);
    cfg(1, 1'b0, 2000);
    cfg(2, 1'b0, 5);
    cfg(3, 1'b0, 37);
    cur_tag = "R9";
    for (int i = 0; i < 60; i++) step(1'b1, int'($urandom % 8000) - 4000, 1'b1, 4);
    cur_tag = "R6";
    for (int i = 0; i < 60; i++) step(1'b1, int'($urandom % 8000) - 4000, 1'b1, 7);
    for (int i = 0; i < 30; i++) step(1'b1, int'($urandom % 8000) - 4000, 1'b1, 2);
    drain(2);

    // R10 distance writes
    cfg(0, 1'b1, 7);
    cfg(1, 1'b1, 10);
    cfg(2, 1'b1, 0);
    cfg(3, 1'b1, 50);
    cur_tag = "R10";
    for (int i = 0; i < 80; i++) step(1'b1, int'($urandom % 8000) - 4000, 1'b1, 4);
    drain(4);

    // R8 saturation at both rails
    cfg(0, 1'b0, 1);
    cfg(1, 1'b0, 2);
    cur_tag = "R8";
    for (int i = 0; i < 10; i++) step(1'b1, 30000, 1'b1, 2);
    for (int i = 0; i < 10; i++) step(1'b1, -30000, 1'b1, 2);
    for (int i = 0; i < 4; i++) step(1'b1, 32767, 1'b1, 3);
    drain(3);

    // constrained random traffic with back-pressure and reconfiguration
    begin
      int tc = 4;
      cur_tag = "R6";
      for (int c = 0; c < 3000; c++) begin
        if ($urandom % 60 == 0) begin
          cfg(int'($urandom % 4), 1'(($urandom) % 2), int'($urandom % 1200));
        end else begin
          int d;
          if ($urandom % 16 == 0) tc = int'($urandom % 8);
          d = ($urandom % 4 == 0) ? (int'($urandom % 65536) - 32768)
                                  : (int'($urandom % 4000) - 2000);
          step(($urandom % 4) != 0, d, ($urandom % 3) != 0, tc);
        end
      end
      drain(tc);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule